// File: doc/BRIEF.md
# Reversible Johnson Enable Counter

This block is a modulo-k twisted-ring (Johnson) counter whose shift direction is chosen every cycle by a direction input. It holds k/2 flip-flops. A one-cycle terminal pulse marks the step that wraps the ring back past its zero state. It is the enable source for one slice of a wide up/down counter. The slice's state register loads only when the pulse fires, so the pulse has to mark the wrap in whichever direction the count is running.

Counting up, the ring fills with ones from bit 0 upward and then empties from bit 0 upward. Counting down, each down step exactly undoes an up step. The terminal pulse follows from the current state and the enable and direction inputs, with no register in between. Upward it fires in the last state before zero, a single one in the top bit. Downward it fires in the zero state. The zero test looks only at the two end bits of the vector. A synchronous clear forces the zero state, and an asynchronous active-low reset does the same.

Top module: `jc_updn_enable`

## Requirements
- R1: While rst_n is 0, ring is all zeros, whatever clr, cnt and dir are doing.
- R2: With cnt=1, clr=0 and dir=1 (up), the next ring has bit i equal to the present bit i-1, and bit 0 equal to the inverse of the present top bit.
- R3: With cnt=1, clr=0 and dir=0 (down), the next ring has bit i equal to the present bit i+1, and the top bit equal to the inverse of the present bit 0.
- R4: With cnt=0 and clr=0 the ring holds its value and wrap is 0.
- R5: With dir=1, wrap is 1 exactly when cnt=1, clr=0 and the ring holds a one in the top bit and zeros in every other bit.
- R6: With dir=0, wrap is 1 exactly when cnt=1, clr=0 and the ring is all zeros. The zero test uses only bit 0 and the top bit.
- R7: clr=1 loads all zeros at the next edge and holds wrap at 0, whatever cnt and dir are.
- R8: A run of k consecutive up steps returns the ring to its starting state, and wrap is 1 on exactly one of those k cycles.
- R9: A down step taken straight after an up step restores the state that came before the up step. The same holds with the two directions swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear to the zero state |
| cnt | input | 1 | Step enable |
| dir | input | 1 | Direction, 1 = up, 0 = down |
| ring | output | MODULUS/2 | Johnson state vector |
| wrap | output | 1 | Terminal pulse, combinational |

## Verification
The bench builds two instances. The first uses MODULUS=8, a four-bit ring. There the up-terminal state 1000 differs from other states that share its end bits, such as 1100 and 1110, and a full cycle of eight states fits in a short run. The second uses MODULUS=2, where the ring is one bit wide. Its up-terminal and zero tests then reduce to opposite values of the same flip-flop, and every step flips the bit. Both instances see continuous up and down runs, a direction flip on every cycle, clear asserted during counting, and random mixes of enable, direction and clear.

// File: rtl/jc_updn_pkg.sv
package jc_updn_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

endpackage

// File: rtl/jc_step_net.sv
// Per-bit multiplexed next-state network for a reversible Johnson ring.
module jc_step_net #(
    parameter int WIDTH = 4
) (
    input  logic             up,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_low;
        logic from_high;

        if (i == 0) begin : g_low_end
            assign from_low = ~cur[WIDTH-1];
        end else begin : g_low_mid
            assign from_low = cur[i-1];
        end

        if (i == WIDTH - 1) begin : g_high_end
            assign from_high = ~cur[0];
        end else begin : g_high_mid
            assign from_high = cur[i+1];
        end

        assign nxt[i] = up ? from_low : from_high;
    end

endmodule

// File: rtl/jc_tc_detect.sv
// Direction-dependent terminal decode; the zero test sees only the end bits.
module jc_tc_detect #(
    parameter int WIDTH = 4
) (
    input  logic             en,
    input  logic             up,
    input  logic [WIDTH-1:0] cur,
    output logic             hit
);

    logic at_last;
    logic at_zero;

    if (WIDTH == 1) begin : g_single
        assign at_last = cur[0];
    end else begin : g_multi
        assign at_last = cur[WIDTH-1] & ~cur[WIDTH-2];
    end

    assign at_zero = ~cur[WIDTH-1] & ~cur[0];
    assign hit     = en & (up ? at_last : at_zero);

endmodule

// File: rtl/jc_updn_enable.sv
module jc_updn_enable
    import jc_updn_pkg::*;
#(
    parameter int MODULUS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   cnt,
    input  logic                   dir,
    output logic [MODULUS/2-1:0]   ring,
    output logic                   wrap
);

    localparam int W = MODULUS / 2;

    typedef struct packed {
        logic [W-1:0] ring;
    } state_t;

    state_t       s_d;
    state_t       s_q;
    logic [W-1:0] step_nxt;
    logic         go_up;
    logic         step_en;

    assign go_up   = (dir_e'(dir) == DIR_UP);
    assign step_en = cnt & ~clr;

    jc_step_net #(.WIDTH(W)) u_step (
        .up  (go_up),
        .cur (s_q.ring),
        .nxt (step_nxt)
    );

    jc_tc_detect #(.WIDTH(W)) u_tc (
        .en  (step_en),
        .up  (go_up),
        .cur (s_q.ring),
        .hit (wrap)
    );

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.ring = '0;
        end else if (cnt) begin
            s_d.ring = step_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ring = s_q.ring;

endmodule

// File: rtl/jc_updn_enable_chk.sv
module jc_updn_enable_chk #(
    parameter int MODULUS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr,
    input logic                 cnt,
    input logic                 dir,
    input logic [MODULUS/2-1:0] ring,
    input logic                 wrap
);

    localparam int W = MODULUS / 2;
    localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        if (!rst_n) AST_RESET_ZERO: assert (ring == '0); // R1
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ring == '0); // R7

    AST_CLR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !wrap); // R7

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt && !clr) |=> $stable(ring)); // R4

    AST_IDLE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt |-> !wrap); // R4

    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt && !clr) |=> ring != $past(ring)); // R2

    AST_UP_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && dir) |=> ring == '0); // R5

    AST_DOWN_WRAP_TO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !dir) |=> ring == TOP_ONLY); // R6

endmodule

bind jc_updn_enable jc_updn_enable_chk #(.MODULUS(MODULUS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .cnt   (cnt),
    .dir   (dir),
    .ring  (ring),
    .wrap  (wrap)
);

// File: tb/tb_jc_updn_enable.sv
`timescale 1ns/1ps
module tb_jc_updn_enable;

    localparam int KA = 8;
    localparam int KB = 2;
    localparam int NCYC = 700;

    logic clk = 1'b0;
    logic rst_n, clr, cnt, dir;
    logic [KA/2-1:0] ring_a;
    logic [KB/2-1:0] ring_b;
    logic wrap_a, wrap_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    jc_updn_enable #(.MODULUS(KA)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cnt(cnt), .dir(dir),
        .ring(ring_a), .wrap(wrap_a)
    );

    jc_updn_enable #(.MODULUS(KB)) dut_b (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cnt(cnt), .dir(dir),
        .ring(ring_b), .wrap(wrap_b)
    );

    // Johnson pattern for ring position p of a k-state ring
    function automatic int unsigned pattern(int p, int k);
        int w = k / 2;
        if (p <= w) return (32'd1 << p) - 1;
        return ((32'd1 << w) - 1) & ~((32'd1 << (p - w)) - 1);
    endfunction

    task automatic check(string tag, string inst, int unsigned got_q,
                         int unsigned exp_q, bit got_t, bit exp_t);
        n_chk++;
        if (got_q !== exp_q || got_t !== exp_t) begin
            n_bad++;
            $display("FAIL %s %s: ring=%0h wrap=%b, expected ring=%0h wrap=%b",
                     tag, inst, got_q, got_t, exp_q, exp_t);
        end
    endtask

    initial begin
        int pa = 0;
        int pb = 0;
        bit prev_dir = 1;
        bit prev_step = 0;
        int wraps = 0;
        rst_n = 0; clr = 0; cnt = 1; dir = 1;
        repeat (3) @(negedge clk);
        check("R1", "k8", ring_a, 0, wrap_a, 1'b0);
        check("R1", "k2", ring_b, 0, wrap_b, 1'b0);
        rst_n = 1;
        for (int n = 0; n < NCYC; n++) begin
            string tag;
            bit ea, eb;
            if (n < 40) begin
                clr = 0; cnt = 1; dir = 1;
            end else if (n < 80) begin
                clr = 0; cnt = 1; dir = 0;
            end else if (n < 120) begin
                clr = 0; cnt = 1; dir = n[0];
            end else if (n < 130) begin
                clr = 1; cnt = 1; dir = n[0];
            end else begin
                clr = ($urandom % 16) == 0;
                cnt = ($urandom % 4) != 0;
                dir = $urandom % 2;
            end
            #1;
            ea = cnt && !clr && (dir ? (pa == KA - 1) : (pa == 0));
            eb = cnt && !clr && (dir ? (pb == KB - 1) : (pb == 0));
            if (clr) tag = "R7";
            else if (!cnt) tag = "R4";
            else if (prev_step && dir != prev_dir) tag = "R9";
            else if (dir && ea) tag = "R5";
            else if (!dir && ea) tag = "R6";
            else if (dir) tag = "R2";
            else tag = "R3";
            check(tag, "k8", ring_a, pattern(pa, KA), wrap_a, ea);
            check(tag, "k2", ring_b, pattern(pb, KB), wrap_b, eb);
            if (n >= 8 && n < 16 + KA) wraps += wrap_a;
            if (n == 16 + KA - 1) begin
                // R8: two full up cycles of the k=8 ring, one pulse each
                check("R8", "k8", ring_a, pattern(pa, KA), wraps, 2);
            end
            prev_step = cnt && !clr;
            prev_dir = dir;
            if (clr) begin
                pa = 0; pb = 0;
            end else if (cnt) begin
                pa = dir ? (pa + 1) % KA : (pa + KA - 1) % KA;
                pb = dir ? (pb + 1) % KB : (pb + KB - 1) % KB;
            end
            @(negedge clk);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule